// File: doc/BRIEF.md
# DMA Channel Request Arbiter

This block decides which of the DMA channels is served next. It watches up to eight request lines. Only channels 0 to 5 are populated, so requests on channels 6 and 7 are masked away. The block issues a one-hot grant for exactly one channel. A grant, once issued, is held until the channel's service is accepted. The block then drops the grant for one cycle before it arbitrates again.

A two-bit mode input chooses the policy. Three of the policies are fixed priority orders, and two of those are irregular permutations rather than a plain rank order. The fourth policy is round robin inside two groups of four channels, with strict priority of the group holding channels 0 to 3 over the group holding channels 4 to 7. Each group keeps its own rotation pointer, which records the last channel of that group whose service was accepted. In a full chip, the mode input is wired to bits 9..8 of the global DMA control word. The accept input is pulsed by the channel datapath when a transfer service completes.

Top module: `dma_chan_arbiter`

## Requirements
- R1: While rst_n is low, grant_o is 0 and grant_valid_o is 0. Both rotation pointers restart so that channel 0 leads the upper group and channel 4 leads the lower group.
- R2: With no grant outstanding, if any populated channel requests, a grant appears on the next rising edge. If no populated channel requests, no grant appears.
- R3: An issued grant keeps the same channel and stays valid, whatever req_i and mode_i do, until accept_i is sampled high.
- R4: accept_i sampled high while a grant is valid clears the grant on that edge. accept_i while no grant is valid has no effect, including on the rotation pointers.
- R5: mode_i = 0 grants in the order 0, 1, 2, 3, 4, 5, 6, 7, from highest to lowest priority.
- R6: mode_i = 1 grants in the order 0, 2, 3, 1, 4, 6, 7, 5, from highest to lowest priority.
- R7: mode_i = 2 grants in the order 2, 0, 1, 3, 6, 4, 5, 7, from highest to lowest priority.
- R8: With mode_i = 3, any request among channels 0 to 3 wins over every request among channels 4 to 7.
- R9: With mode_i = 3, each group is searched starting just after the last channel of that group whose grant was accepted, wrapping within the group. A group's pointer moves only when a grant to one of its own channels is accepted, in any mode.
- R10: Channels 6 and 7 are never granted, even when they request.
- R11: grant_o has at most one bit set. Bit n set means channel n is granted. grant_id_o carries n in binary, and grant_valid_o is high while a grant is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 8 | Request line per channel, bit n for channel n |
| mode_i | input | 2 | Arbitration policy select (0..3) |
| accept_i | input | 1 | Completion of the granted channel's service |
| grant_o | output | 8 | One-hot grant, bit n for channel n |
| grant_valid_o | output | 1 | A grant is being held |
| grant_id_o | output | 3 | Binary index of the granted channel |

## Verification
The hardest state to reach from the ports is a round-robin pointer that has moved in one group while the other group's pointer sits at a value other than its reset value. Only that state shows that the pointers are independent, and that an accept pulse arriving while no grant is held leaves them untouched. The stimulus reaches it in steps. It applies a fresh reset, walks the upper group through a full lap, and then serves the lower group twice. Next it pulses accept with no grant held and mixes upper and lower requests. Each resulting grant exposes a specific pointer value. A behavioural reference model, compared on every clock, covers all the intervening cycles.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  localparam int unsigned CH_MAX   = 8;
  localparam int unsigned CH_IDX_W = $clog2(CH_MAX);

  typedef logic [CH_IDX_W-1:0] chan_id_t;

  typedef enum logic [1:0] {
    ARB_LINEAR = 2'd0,
    ARB_PERM_A = 2'd1,
    ARB_PERM_B = 2'd2,
    ARB_ROTATE = 2'd3
  } arb_mode_e;

  // Rank r occupies bits [3r +: 3]; rank 0 is the highest priority.
  localparam logic [CH_MAX*CH_IDX_W-1:0] PERM_A =
    {3'd5, 3'd7, 3'd6, 3'd4, 3'd1, 3'd3, 3'd2, 3'd0};
  localparam logic [CH_MAX*CH_IDX_W-1:0] PERM_B =
    {3'd7, 3'd5, 3'd4, 3'd6, 3'd3, 3'd1, 3'd0, 3'd2};

  function automatic chan_id_t rank_to_chan(input arb_mode_e m, input chan_id_t rank);
    chan_id_t c;
    case (m)
      ARB_PERM_A: c = PERM_A[int'(rank)*CH_IDX_W +: CH_IDX_W];
      ARB_PERM_B: c = PERM_B[int'(rank)*CH_IDX_W +: CH_IDX_W];
      default:    c = rank;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/dma_prio_pick.sv
module dma_prio_pick
  import dma_arb_pkg::*;
(
  input  logic [CH_MAX-1:0] req_i,
  input  arb_mode_e         mode_i,
  output logic              hit_o,
  output chan_id_t          chan_o
);

  chan_id_t at_rank [CH_MAX];

  for (genvar r = 0; r < CH_MAX; r++) begin : g_rank
    assign at_rank[r] = rank_to_chan(mode_i, chan_id_t'(r));
  end

  // Walk from lowest to highest rank so the highest-ranked hit is kept.
  always_comb begin
    hit_o  = 1'b0;
    chan_o = '0;
    for (int r = int'(CH_MAX) - 1; r >= 0; r--) begin
      if (req_i[at_rank[r]]) begin
        hit_o  = 1'b1;
        chan_o = at_rank[r];
      end
    end
  end

endmodule

// File: rtl/dma_rr_group.sv
module dma_rr_group #(
  parameter  int unsigned GW = 4,
  localparam int unsigned IW = (GW > 1) ? $clog2(GW) : 1
) (
  input  logic [GW-1:0] req_i,
  input  logic [IW-1:0] last_i,
  output logic          hit_o,
  output logic [IW-1:0] idx_o
);

  logic [IW-1:0] probe;

  // Search offsets GW down to 1 so the nearest position after last_i wins.
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    probe = '0;
    for (int k = int'(GW); k >= 1; k--) begin
      probe = IW'((int'(last_i) + k) % int'(GW));
      if (req_i[probe]) begin
        hit_o = 1'b1;
        idx_o = probe;
      end
    end
  end

endmodule

// File: rtl/dma_chan_arbiter.sv
module dma_chan_arbiter
  import dma_arb_pkg::*;
#(
  parameter logic [CH_MAX-1:0] POP_MASK = 8'h3F,
  parameter int unsigned       GROUP_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CH_MAX-1:0] req_i,
  input  logic [1:0]        mode_i,
  input  logic              accept_i,
  output logic [CH_MAX-1:0] grant_o,
  output logic              grant_valid_o,
  output logic [CH_IDX_W-1:0] grant_id_o
);

  localparam int unsigned NGRP  = CH_MAX / GROUP_W;
  localparam int unsigned GIW   = $clog2(GROUP_W);
  localparam int unsigned GSELW = (NGRP > 1) ? $clog2(NGRP) : 1;

  arb_mode_e          mode;
  logic [CH_MAX-1:0]  req_live;
  logic               fix_hit;
  chan_id_t           fix_chan;
  logic [NGRP-1:0]    rr_hit;
  logic [GIW-1:0]     rr_idx [NGRP];
  logic [GIW-1:0]     ptr_q  [NGRP];
  logic [NGRP-1:0]    ptr_en;
  logic               rr_found;
  chan_id_t           rr_chan;
  logic               win_hit;
  chan_id_t           win_chan;
  logic               busy_q, busy_d;
  chan_id_t           cur_q;
  logic               grant_load, grant_done;
  logic [GSELW-1:0]   cur_grp;
  logic [GIW-1:0]     cur_loc;

  assign mode     = arb_mode_e'(mode_i);
  assign req_live = req_i & POP_MASK;
  assign cur_grp  = GSELW'(cur_q >> GIW);
  assign cur_loc  = cur_q[GIW-1:0];

  dma_prio_pick u_fixed (
    .req_i  (req_live),
    .mode_i (mode),
    .hit_o  (fix_hit),
    .chan_o (fix_chan)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    dma_rr_group #(.GW(GROUP_W)) u_rr (
      .req_i  (req_live[g*GROUP_W +: GROUP_W]),
      .last_i (ptr_q[g]),
      .hit_o  (rr_hit[g]),
      .idx_o  (rr_idx[g])
    );

    assign ptr_en[g] = grant_done && (int'(cur_grp) == g);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          ptr_q[g] <= '1;
      else if (ptr_en[g])  ptr_q[g] <= cur_loc;
    end

    // A group pointer only moves when one of its own grants is accepted.
    assert_ptr_move_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ptr_q[g]) |-> $past(grant_done) && ($past(int'(cur_grp)) == g));
  end

  // Lower group index means higher priority between groups.
  always_comb begin
    rr_found = 1'b0;
    rr_chan  = '0;
    for (int g = int'(NGRP) - 1; g >= 0; g--) begin
      if (rr_hit[g]) begin
        rr_found = 1'b1;
        rr_chan  = chan_id_t'(g * int'(GROUP_W) + int'(rr_idx[g]));
      end
    end
  end

  assign win_hit  = (mode == ARB_ROTATE) ? rr_found : fix_hit;
  assign win_chan = (mode == ARB_ROTATE) ? rr_chan  : fix_chan;

  assign grant_load = !busy_q && win_hit;
  assign grant_done = busy_q && accept_i;

  always_comb begin
    busy_d = busy_q;
    if (grant_done)      busy_d = 1'b0;
    else if (grant_load) busy_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cur_q  <= '0;
    end else begin
      busy_q <= busy_d;
      if (grant_load) cur_q <= win_chan;
    end
  end

  always_comb begin
    grant_o = '0;
    if (busy_q) grant_o[cur_q] = 1'b1;
  end
  assign grant_valid_o = busy_q;
  assign grant_id_o    = cur_q;

  assert_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

  assert_no_ghost_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o & ~POP_MASK) == '0);

  assert_issue_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_valid_o && (req_live != '0) |=> grant_valid_o);

  assert_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_valid_o && (req_live == '0) |=> !grant_valid_o);

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid_o && !accept_i |=> grant_valid_o && $stable(grant_o));

  assert_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid_o && accept_i |=> !grant_valid_o);

  assert_upper_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_valid_o && (mode == ARB_ROTATE) && (req_live[GROUP_W-1:0] != '0)
    |=> int'(grant_id_o) < int'(GROUP_W));

endmodule

// File: tb/dma_chan_arbiter_bench.sv
`timescale 1ns/1ps
module dma_chan_arbiter_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] req;
  logic [1:0] mode;
  logic       accept;
  logic [7:0] grant_o;
  logic       grant_valid_o;
  logic [2:0] grant_id_o;

  always #2 clk = ~clk;

  dma_chan_arbiter u_dma_chan_arbiter (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_i         (req),
    .mode_i        (mode),
    .accept_i      (accept),
    .grant_o       (grant_o),
    .grant_valid_o (grant_valid_o),
    .grant_id_o    (grant_id_o)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done  = 0;
  string phase = "R1";

  // Behavioural reference model
  int m_busy = 0;
  int m_cur  = 0;
  int m_last [2] = '{3, 3};
  int order [3][8] = '{'{0,1,2,3,4,5,6,7}, '{0,2,3,1,4,6,7,5}, '{2,0,1,3,6,4,5,7}};

  function automatic int m_pick(input logic [7:0] r, input int md);
    logic [7:0] live;
    live = r & 8'h3F;
    if (md < 3) begin
      for (int k = 0; k < 8; k++)
        if (live[order[md][k]]) return order[md][k];
      return -1;
    end
    for (int g = 0; g < 2; g++)
      for (int k = 1; k <= 4; k++) begin
        int j;
        j = (m_last[g] + k) % 4;
        if (live[g*4 + j]) return g*4 + j;
      end
    return -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0;
      m_cur  = 0;
      m_last = '{3, 3};
    end else if (m_busy != 0) begin
      if (accept) begin
        m_busy = 0;
        m_last[m_cur / 4] = m_cur % 4;
      end
    end else begin
      int w;
      w = m_pick(req, int'(mode));
      if (w >= 0) begin
        m_busy = 1;
        m_cur  = w;
      end
    end
  end

  task automatic check_val(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Every-cycle comparison against the model (R11 grant encoding)
  always @(negedge clk) begin
    if (!done) begin
      int eg;
      eg = (m_busy != 0) ? (1 << m_cur) : 0;
      check_val({phase, " R11 grant vector"}, int'(grant_o), eg);
      check_val({phase, " valid"}, int'(grant_valid_o), m_busy);
      if (m_busy != 0) check_val({phase, " R11 id"}, int'(grant_id_o), m_cur);
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic serve(input logic [7:0] r, input logic [1:0] m, input int exp, input string tag);
    phase  = tag;
    req    = r;
    mode   = m;
    accept = 1'b0;
    @(negedge clk);
    if (exp < 0) begin
      check_val({tag, " no grant"}, int'(grant_valid_o), 0);
      @(negedge clk);
      check_val({tag, " still no grant"}, int'(grant_o), 0);
      req = '0;
      @(negedge clk);
    end else begin
      check_val({tag, " granted"}, int'(grant_valid_o), 1);
      check_val({tag, " channel"}, int'(grant_id_o), exp);
      accept = 1'b1;
      @(negedge clk);
      accept = 1'b0;
      req    = '0;
      check_val({tag, " R4 released"}, int'(grant_valid_o), 0);
    end
  endtask

  task automatic do_reset();
    phase = "R1";
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check_val("R1 reset grant", int'(grant_o), 0);
    check_val("R1 reset valid", int'(grant_valid_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    req    = '0;
    mode   = '0;
    accept = 1'b0;
    do_reset();

    phase = "R2";
    check_val("R2 no request no grant", int'(grant_valid_o), 0);

    serve(8'h3E, 2'd0, 1, "R5 linear");
    serve(8'h30, 2'd0, 4, "R5 linear low");
    serve(8'h22, 2'd1, 1, "R6 perm A 1 over 5");
    serve(8'h12, 2'd1, 1, "R6 perm A 1 over 4");
    serve(8'h0A, 2'd1, 3, "R6 perm A 3 over 1");
    serve(8'h30, 2'd1, 4, "R6 perm A 4 over 5");
    serve(8'h05, 2'd2, 2, "R7 perm B 2 over 0");
    serve(8'h18, 2'd2, 3, "R7 perm B 3 over 4");
    serve(8'h30, 2'd2, 4, "R7 perm B 4 over 5");
    serve(8'h03, 2'd2, 0, "R7 perm B 0 over 1");
    serve(8'hC0, 2'd0, -1, "R10 only absent channels");
    serve(8'hC0, 2'd2, -1, "R10 absent in perm B");
    serve(8'hA0, 2'd0, 5, "R10 channel 7 skipped");

    // R3: grant held while request and mode change
    phase = "R3";
    req = 8'h04; mode = 2'd0;
    @(negedge clk);
    check_val("R3 initial grant", int'(grant_id_o), 2);
    req = 8'h01; mode = 2'd2;
    repeat (3) begin
      @(negedge clk);
      check_val("R3 held id", int'(grant_id_o), 2);
      check_val("R3 held valid", int'(grant_valid_o), 1);
    end
    accept = 1'b1;
    @(negedge clk);
    accept = 1'b0; req = '0;
    check_val("R4 accept clears", int'(grant_valid_o), 0);
    @(negedge clk);

    // Round robin from a fresh reset
    do_reset();
    serve(8'h3F, 2'd3, 0, "R9 lap 0");
    serve(8'h3F, 2'd3, 1, "R9 lap 1");
    serve(8'h3F, 2'd3, 2, "R9 lap 2");
    serve(8'h3F, 2'd3, 3, "R9 lap 3");
    serve(8'h3F, 2'd3, 0, "R9 wrap");
    serve(8'h30, 2'd3, 4, "R9 lower first");
    serve(8'h30, 2'd3, 5, "R9 lower next");
    serve(8'h31, 2'd3, 0, "R8 upper beats lower");
    serve(8'h30, 2'd3, 4, "R9 lower skips absent");
    phase = "R4 idle accept";
    accept = 1'b1;
    @(negedge clk);
    accept = 1'b0;
    check_val("R4 idle accept no grant", int'(grant_valid_o), 0);
    serve(8'hF0, 2'd3, 5, "R4 pointer unchanged");
    serve(8'hC0, 2'd3, -1, "R10 rotate absent");
    serve(8'h0A, 2'd3, 1, "R9 upper resume");
    serve(8'h0A, 2'd3, 3, "R9 upper rotate");
    serve(8'h30, 2'd3, 4, "R9 lower independent");

    done = 1;
    summary();
    $finish;
  end

endmodule